// File: doc/BRIEF.md
# Control Register Bank Behind an I2C Target

This block lets a host program a small set of 8-bit control registers over a two-wire I2C bus. The registers set up the audio and video paths of a mixed-signal driver. The block answers only to one fixed 7-bit device address. A write carries a register index and then any number of data bytes. The index steps forward after every byte.

Reads come in two kinds:
- A current-address read starts at the register after the last one touched.
- A random read first writes only the register index. It then issues a repeated START and reads from that index.

The contents of every register are presented as one wide parallel vector, so the analog side can decode its fields directly. An active-low power-down input clears the control logic and reloads every register's default value without waiting for the clock. SCL and SDA arrive as raw pad levels and are synchronised inside the block. SDA is driven open-drain through an output enable that pulls the line low.

Top module: `ctl_i2c_regbank`

## Requirements
- R1: After a START, the block acknowledges only when the first seven bits received equal 7'b0010001. The eighth bit selects read (1) or write (0). For any other address it stays off the bus until the next START.
- R2: In a write, the second byte is the register index, taken from its low five bits. Every later byte is stored into the indexed register. All bytes are received MSB first, and the block acknowledges each one.
- R3: After each byte is written, the index advances by one. An index of 13 (0Dh) or higher wraps to 0.
- R4: After each byte is read, the index advances by one. An index of 9 (09h) or higher wraps to 0.
- R5: A read with no preceding index write returns the register at the current index, which is one past the last register accessed.
- R6: A repeated START followed by a read address returns data starting at the index written just before it.
- R7: When the host does not acknowledge a read byte, the block stops driving SDA and waits for STOP or START.
- R8: While pdn_n is low, every register holds its default without waiting for a clock edge. The defaults are reg0=0Bh, reg1=95h, reg3=27h, reg4=1Ch, reg6=04h, reg10=03h and reg13=1Fh. All other registers default to 00h.
- R9: A write to an index above 13 changes no register. A read of such an index returns 00h.
- R10: sda_oe_o is high only while the block sends an acknowledge or a read data bit that is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus bit rate |
| pdn_n | input | 1 | Active-low power-down and asynchronous reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level |
| sda_oe_o | output | 1 | When high, pull SDA low |
| regs_o | output | 112 | Register contents; register k occupies bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters:
- 14 registers, so the index range 14 to 31 is unimplemented.
- Write wrap at 13 and read wrap at 9.
- Two synchroniser stages.

With these values, a burst of three bytes starting at index 12 reaches the write wrap, and a three-byte read from index 8 reaches the read wrap. A single write at index 14 exercises the unimplemented range on both the write and the read side. The bus quarter-period of ten clocks leaves room for the synchroniser and edge-detect latency before the host samples an acknowledge or a data bit.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ACK_A, ST_SUB, ST_ACK_S,
        ST_WDATA, ST_ACK_D, ST_RDATA, ST_RACK
    } tgt_state_e;

    function automatic logic [7:0] reg_default(input int unsigned idx);
        case (idx)
            0:       return 8'h0B;
            1:       return 8'h95;
            3:       return 8'h27;
            4:       return 8'h1C;
            6:       return 8'h04;
            10:      return 8'h03;
            13:      return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_s;

    always_comb begin
        sync_d        = sync_q;
        sync_d.scl_sh = {sync_q.scl_sh[STAGES-2:0], scl_i};
        sync_d.sda_sh = {sync_q.sda_sh[STAGES-2:0], sda_i};
        sync_d.scl_p  = sync_q.scl_sh[STAGES-1];
        sync_d.sda_p  = sync_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_s     = sync_q.scl_sh[STAGES-1];
    assign sda_s     = sync_q.sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~sync_q.scl_p;
    assign scl_fall  = ~scl_s & sync_q.scl_p;
    assign start_det = scl_s & sync_q.scl_p & sync_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & sync_q.scl_p & ~sync_q.sda_p & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import ctl_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h11,
    parameter int         IDX_W    = 5,
    parameter int         WR_LAST  = 13,
    parameter int         RD_LAST  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] idx,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    typedef struct packed {
        tgt_state_e       st;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic [IDX_W-1:0] ptr;
        logic             rw;
        logic             mack;
        logic             oe;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [IDX_W-1:0] wr_next, rd_next;

    assign wr_next = (fsm_q.ptr >= IDX_W'(WR_LAST)) ? '0 : fsm_q.ptr + 1'b1;
    assign rd_next = (fsm_q.ptr >= IDX_W'(RD_LAST)) ? '0 : fsm_q.ptr + 1'b1;

    always_comb begin
        fsm_d = fsm_q;
        wr_en = 1'b0;
        if (stop_det) begin
            fsm_d.st = ST_IDLE;
            fsm_d.oe = 1'b0;
        end else if (start_det) begin
            fsm_d.st  = ST_ADDR;
            fsm_d.cnt = '0;
            fsm_d.oe  = 1'b0;
        end else begin
            case (fsm_q.st)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (scl_rise) begin
                        fsm_d.sh  = {fsm_q.sh[6:0], sda_s};
                        fsm_d.cnt = fsm_q.cnt + 4'd1;
                    end else if (scl_fall && fsm_q.cnt == 4'd8) begin
                        fsm_d.cnt = '0;
                        fsm_d.oe  = 1'b1;
                        if (fsm_q.st == ST_ADDR) begin
                            if (fsm_q.sh[7:1] == DEV_ADDR) begin
                                fsm_d.st = ST_ACK_A;
                                fsm_d.rw = fsm_q.sh[0];
                            end else begin
                                fsm_d.st = ST_IDLE;
                                fsm_d.oe = 1'b0;
                            end
                        end else if (fsm_q.st == ST_SUB) begin
                            fsm_d.st  = ST_ACK_S;
                            fsm_d.ptr = fsm_q.sh[IDX_W-1:0];
                        end else begin
                            fsm_d.st  = ST_ACK_D;
                            wr_en     = 1'b1;
                            fsm_d.ptr = wr_next;
                        end
                    end
                end
                ST_ACK_A, ST_ACK_S, ST_ACK_D: begin
                    if (scl_fall) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.st == ST_ACK_A && fsm_q.rw) begin
                            fsm_d.st  = ST_RDATA;
                            fsm_d.sh  = rd_data;
                            fsm_d.ptr = rd_next;
                            fsm_d.oe  = ~rd_data[7];
                        end else begin
                            fsm_d.st = (fsm_q.st == ST_ACK_A) ? ST_SUB : ST_WDATA;
                            fsm_d.oe = 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (fsm_q.cnt == 4'd7) begin
                            fsm_d.st  = ST_RACK;
                            fsm_d.cnt = '0;
                            fsm_d.oe  = 1'b0;
                        end else begin
                            fsm_d.cnt = fsm_q.cnt + 4'd1;
                            fsm_d.sh  = {fsm_q.sh[6:0], 1'b0};
                            fsm_d.oe  = ~fsm_q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        fsm_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (fsm_q.mack) begin
                            fsm_d.st  = ST_RDATA;
                            fsm_d.sh  = rd_data;
                            fsm_d.ptr = rd_next;
                            fsm_d.oe  = ~rd_data[7];
                        end else begin
                            fsm_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE, default: '0};
        else        fsm_q <= fsm_d;
    end

    assign idx     = fsm_q.ptr;
    assign wr_data = fsm_q.sh;
    assign sda_oe  = fsm_q.oe;

    // R1
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_ACK_A) |-> (fsm_q.sh[7:1] == DEV_ADDR));
    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_IDLE || fsm_q.st == ST_ADDR) |-> !sda_oe);
    // R7
    rack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_RACK) |-> !sda_oe);
    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (idx == '0 || idx == $past(idx) + 1'b1));
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import ctl_i2c_pkg::*;
#(
    parameter int NUM_REGS = 14,
    parameter int IDX_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    output logic [8*NUM_REGS-1:0] regs_flat
);
    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
            if (idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
                if (wr_en) regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i);
        end else begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_flat[8*g +: 8] = regs_q[g];
    end

    // R9
    unimpl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx >= IDX_W'(NUM_REGS)) |=> $stable(regs_flat));
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank #(
    parameter logic [6:0] DEV_ADDR    = 7'h11,
    parameter int         NUM_REGS    = 14,
    parameter int         WR_LAST     = 13,
    parameter int         RD_LAST     = 9,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  pdn_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [8*NUM_REGS-1:0] regs_o
);
    localparam int IDX_W = 5;

    logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [IDX_W-1:0] idx;
    logic             wr_en;
    logic [7:0]       wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(pdn_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_target_fsm #(
        .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W), .WR_LAST(WR_LAST), .RD_LAST(RD_LAST)
    ) fsm_i (
        .clk(clk), .rst_n(pdn_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .idx(idx), .wr_en(wr_en), .wr_data(wr_data),
        .sda_oe(sda_oe_o)
    );

    ctl_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) regs_i (
        .clk(clk), .rst_n(pdn_n), .wr_en(wr_en), .idx(idx),
        .wr_data(wr_data), .rd_data(rd_data), .regs_flat(regs_o)
    );
endmodule

// File: tb/ctl_i2c_regbank_tb_top.sv
`timescale 1ns/1ps
module ctl_i2c_regbank_tb_top;
    localparam int NREG = 14;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic pdn_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [8*NREG-1:0] regs;
    logic sda_line;
    int   n_chk = 0;
    int   n_err = 0;
    int   oe_cnt = 0;
    logic [7:0] model [NREG];

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;
    always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

    ctl_i2c_regbank dut_i (
        .clk(clk), .pdn_n(pdn_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    function automatic logic [7:0] dflt(int k);
        logic [7:0] v;
        v = 8'h00;
        if (k == 0)  v = 8'h0B;
        if (k == 1)  v = 8'h95;
        if (k == 3)  v = 8'h27;
        if (k == 4)  v = 8'h1C;
        if (k == 6)  v = 8'h04;
        if (k == 10) v = 8'h03;
        if (k == 13) v = 8'h1F;
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        for (int k = 0; k < NREG; k++) chk(req, {24'h0, regs[8*k +: 8]}, {24'h0, model[k]});
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic send_bit(logic b);
        sda_m = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    endtask

    task automatic wbyte(logic [7:0] d, output logic ack);
        for (int b = 7; b >= 0; b--) send_bit(d[b]);
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); ack = ~sda_line; qw(); scl = 1'b0; qw();
    endtask

    task automatic rbyte(logic give_ack, output logic [7:0] d);
        d = 8'h00;
        for (int b = 0; b < 8; b++) begin
            sda_m = 1'b1; qw(); scl = 1'b1; qw(); d = {d[6:0], sda_line}; qw(); scl = 1'b0; qw();
        end
        send_bit(~give_ack);
    endtask

    task automatic t_reset();
        chk("R10 idle oe", {31'h0, sda_oe}, 32'h0);
        chk_all("R8 defaults");
    endtask

    task automatic t_write_single();
        logic a0, a1, a2;
        bus_start(); wbyte(8'h22, a0); wbyte(8'h05, a1); wbyte(8'hA5, a2); bus_stop();
        model[5] = 8'hA5;
        chk("R2 acks", {29'h0, a0, a1, a2}, 32'h7);
        chk("R2 msb-first data", {24'h0, regs[8*5 +: 8]}, 32'hA5);
    endtask

    task automatic t_wrong_addr();
        logic a0, a1;
        oe_cnt = 0;
        bus_start(); wbyte(8'h24, a0); wbyte(8'h05, a1); bus_stop();
        chk("R1 nack foreign addr", {30'h0, a0, a1}, 32'h0);
        chk("R10 no drive when unaddressed", oe_cnt, 0);
        chk_all("R1 regs untouched");
    endtask

    task automatic t_burst_wrap();
        logic a;
        bus_start(); wbyte(8'h22, a); wbyte(8'h0C, a);
        wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); bus_stop();
        model[12] = 8'h11; model[13] = 8'h22; model[0] = 8'h33;
        chk("R3 last ack", {31'h0, a}, 32'h1);
        chk_all("R3 write wrap");
    endtask

    task automatic t_random_read();
        logic a0, a1;
        logic [7:0] d0, d1;
        bus_start(); wbyte(8'h22, a0); wbyte(8'h05, a0);
        bus_start(); wbyte(8'h23, a1);
        rbyte(1'b1, d0); rbyte(1'b0, d1);
        qw();
        chk("R7 released after nack", {31'h0, sda_oe}, 32'h0);
        bus_stop();
        chk("R6 read ack", {31'h0, a1}, 32'h1);
        chk("R6 first byte", {24'h0, d0}, {24'h0, model[5]});
        chk("R6 second byte", {24'h0, d1}, {24'h0, model[6]});
    endtask

    task automatic t_current_read();
        logic a;
        logic [7:0] d0, d1;
        bus_start(); wbyte(8'h22, a); wbyte(8'h03, a); wbyte(8'h66, a); bus_stop();
        model[3] = 8'h66;
        bus_start(); wbyte(8'h23, a); rbyte(1'b0, d0); bus_stop();
        bus_start(); wbyte(8'h23, a); rbyte(1'b0, d1); bus_stop();
        chk("R5 current read", {24'h0, d0}, {24'h0, model[4]});
        chk("R5 next current read", {24'h0, d1}, {24'h0, model[5]});
    endtask

    task automatic t_read_wrap();
        logic a;
        logic [7:0] d0, d1, d2;
        bus_start(); wbyte(8'h22, a); wbyte(8'h08, a); wbyte(8'h81, a); wbyte(8'h92, a); bus_stop();
        model[8] = 8'h81; model[9] = 8'h92;
        bus_start(); wbyte(8'h22, a); wbyte(8'h08, a);
        bus_start(); wbyte(8'h23, a);
        rbyte(1'b1, d0); rbyte(1'b1, d1); rbyte(1'b0, d2); bus_stop();
        chk("R4 reg8", {24'h0, d0}, 32'h81);
        chk("R4 reg9", {24'h0, d1}, 32'h92);
        chk("R4 wrap to reg0", {24'h0, d2}, {24'h0, model[0]});
    endtask

    task automatic t_unimpl();
        logic a;
        logic [7:0] d0, d1;
        bus_start(); wbyte(8'h22, a); wbyte(8'h0E, a); wbyte(8'hFF, a); bus_stop();
        chk("R9 write acked", {31'h0, a}, 32'h1);
        chk_all("R9 write ignored");
        bus_start(); wbyte(8'h22, a); wbyte(8'h0E, a);
        bus_start(); wbyte(8'h23, a);
        rbyte(1'b1, d0); rbyte(1'b0, d1); bus_stop();
        chk("R9 unimplemented reads zero", {24'h0, d0}, 32'h0);
        chk("R4 wrap from high index", {24'h0, d1}, {24'h0, model[0]});
    endtask

    task automatic t_pdn();
        logic a;
        @(posedge clk); #1 pdn_n = 1'b0;
        #0.5;
        for (int k = 0; k < NREG; k++) model[k] = dflt(k);
        chk_all("R8 async defaults");
        @(negedge clk); pdn_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_start(); wbyte(8'h22, a); wbyte(8'h02, a); wbyte(8'h3C, a); bus_stop();
        model[2] = 8'h3C;
        chk_all("R2 write after power-down");
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < NREG; k++) model[k] = dflt(k);
        repeat (5) @(negedge clk);
        t_reset();
        pdn_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_single();
        t_wrong_addr();
        t_burst_wrap();
        t_random_read();
        t_current_read();
        t_read_wrap();
        t_unimpl();
        t_pdn();
        finish_run();
    end
endmodule